// File: doc/BRIEF.md
# Read Sequencer with Area-Change Idle Gap

This block runs read cycles on an external bus that is split into several chip-select areas. A requester hands it one address at a time over a valid/ready handshake. The top address bits pick the area. The block drives the address, one active-low select per area and a shared active-low read strobe. It samples the read data at the end of the access and returns it with a one-cycle pulse.

A slow read strobe from one device can still be low when the next device's select goes active. To prevent that overlap, the sequencer can place one dead state between two back-to-back reads whose areas differ. In that state no select and no strobe are active. A configuration bit enables this gap, and it comes out of reset enabled. The same configuration write also sets, for each area, whether an access takes two or three bus states.

Top module: `rd_idle_seq`

## Requirements
- R1: After reset every `bus_cs_n` bit is 1, `bus_rd_n` is 1, `rsp_valid` is 0 and `req_ready` is 1. The gap enable resets to 1 and every area resets to three-state access.
- R2: The area of a request is `req_addr[AW-1 -: $clog2(NAREA)]`. During that access only `bus_cs_n[area]` is 0, and `bus_addr` equals the request address.
- R3: A request accepted at a clock edge drives select and strobe low from the next cycle onward. They stay low for 2 cycles if the area's `cfg_slow` bit is 0, or for 3 cycles if it is 1.
- R4: `rsp_valid` is high for exactly one cycle, the cycle after an access's last state. `rsp_data` then holds the `bus_data_i` value sampled at the end of that last state.
- R5: `req_ready` is 1 when the sequencer is idle or in the last state of an access, and 0 in every other state.
- R6: With the gap enabled, a request accepted in the last state of a read to a different area gets exactly one cycle with all selects and the strobe high before its first state.
- R7: With the gap disabled, a request accepted in the last state of the previous read starts its first state in the very next cycle, even when the area differs.
- R8: A request accepted in the last state of a read to the same area starts in the next cycle, with no gap, whatever the gap enable says.
- R9: A request accepted while the bus is idle never gets a gap state.
- R10: A cycle with `cfg_we` high loads the gap enable from `cfg_idle_en` and the per-area access lengths from `cfg_slow` (bit n for area n; 1 means three states).
- R11: At most one `bus_cs_n` bit is 0 at a time, and `bus_rd_n` is 0 exactly when some select is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load the configuration |
| cfg_idle_en | input | 1 | Gap enable value to load |
| cfg_slow | input | NAREA | Per-area three-state select to load |
| req_valid | input | 1 | Read request present |
| req_addr | input | AW | Read address |
| req_ready | output | 1 | Request can be taken this cycle |
| bus_addr | output | AW | External address |
| bus_cs_n | output | NAREA | Active-low area selects |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_data_i | input | DW | External read data |
| rsp_valid | output | 1 | One-cycle read-done pulse |
| rsp_data | output | DW | Read data |

## Verification
A wrong state register appears on the bus pins in the very next cycle. A lost or extra gap shifts the second access's select by one cycle. A wrong length moves the strobe's rising edge, and with it the done pulse. A stale area or address shows up as the wrong select bit or as wrong returned data. The bench therefore compares select, strobe, ready and the done pulse against a timeline computed for every cycle of each request pair, so any such fault is seen within a few cycles of its cause.

// File: rtl/rd_idle_seq.sv
module rd_idle_seq #(
  parameter int NAREA = 4,
  parameter int AW    = 16,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_idle_en,
  input  logic [NAREA-1:0] cfg_slow,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  output logic             req_ready,
  output logic [AW-1:0]    bus_addr,
  output logic [NAREA-1:0] bus_cs_n,
  output logic             bus_rd_n,
  input  logic [DW-1:0]    bus_data_i,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_data
);
  localparam int AB = (NAREA > 1) ? $clog2(NAREA) : 1;

  typedef enum logic [2:0] {S_IDLE, S_GAP, S_T1, S_T2, S_T3} st_t;

  st_t              st;
  logic [AW-1:0]    cur_addr;
  logic             cur_slow;
  logic             idle_en_q;
  logic [NAREA-1:0] slow_q;

  wire [AB-1:0] req_area = req_addr[AW-1 -: AB];
  wire [AB-1:0] cur_area = cur_addr[AW-1 -: AB];
  wire last_st  = (st == S_T2 && !cur_slow) || st == S_T3;
  wire active   = (st == S_T1) || (st == S_T2) || (st == S_T3);
  wire accept   = req_valid && req_ready;
  wire need_gap = (st != S_IDLE) && idle_en_q && (req_area != cur_area);

  assign req_ready = (st == S_IDLE) || last_st;
  assign bus_addr  = cur_addr;
  assign bus_rd_n  = !active;
  assign bus_cs_n  = active ? ~(NAREA'(1) << cur_area) : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cur_addr  <= '0;
      cur_slow  <= 1'b0;
      idle_en_q <= 1'b1;
      slow_q    <= '1;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= last_st;
      if (last_st) rsp_data <= bus_data_i;
      if (cfg_we) begin
        idle_en_q <= cfg_idle_en;
        slow_q    <= cfg_slow;
      end
      if (accept) begin
        cur_addr <= req_addr;
        cur_slow <= slow_q[req_area];
        st       <= need_gap ? S_GAP : S_T1;
      end else begin
        case (st)
          S_GAP:   st <= S_T1;
          S_T1:    st <= S_T2;
          S_T2:    st <= cur_slow ? S_T3 : S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rd_idle_seq_chk.sv
module rd_idle_seq_chk #(
  parameter int NAREA = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NAREA-1:0] bus_cs_n,
  input logic             bus_rd_n,
  input logic             rsp_valid,
  input logic             idle_en_q
);
  p_cs_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n));

  p_rd_tracks_cs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_n == (&bus_cs_n));

  p_area_change_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_en_q && !(&$past(bus_cs_n)) && !(&bus_cs_n)) |-> bus_cs_n == $past(bus_cs_n));

  p_rsp_after_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !$past(bus_rd_n));

  p_rsp_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind rd_idle_seq rd_idle_seq_chk #(.NAREA(NAREA)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
  .rsp_valid(rsp_valid), .idle_en_q(idle_en_q)
);

// File: tb/rd_idle_seq_bench.sv
`timescale 1ns/1ps
module rd_idle_seq_bench;
  localparam int NAREA = 4;
  localparam int AW = 16;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_idle_en = 1'b0;
  logic [NAREA-1:0] cfg_slow = '0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, bus_rd_n, rsp_valid;
  logic [AW-1:0] bus_addr;
  logic [NAREA-1:0] bus_cs_n;
  logic [DW-1:0] bus_data_i, rsp_data;

  int tests = 0, fails = 0;
  logic m_idle = 1'b1;
  logic [NAREA-1:0] m_slow = '1;

  always #2.5 clk = ~clk;

  assign bus_data_i = bus_addr ^ 16'h5A3C;

  rd_idle_seq #(.NAREA(NAREA), .AW(AW), .DW(DW)) u_rd_idle_seq (.*);

  function automatic int area_of(logic [AW-1:0] a);
    return int'(a[AW-1 -: 2]);
  endfunction
  function automatic int len_of(logic [AW-1:0] a);
    return m_slow[area_of(a)] ? 3 : 2;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_cfg(logic ie, logic [NAREA-1:0] sl);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idle_en = ie; cfg_slow = sl;
    @(negedge clk);
    cfg_we = 1'b0;
    m_idle = ie; m_slow = sl;
  endtask

  // b2b=1: second request held so it is taken in the first access's last state
  task automatic run_pair(logic [AW-1:0] a1, logic [AW-1:0] a2, bit b2b, string tag);
    int la, lb, g, sb;
    logic [NAREA-1:0] ecs;
    logic erd, erdy, ersp;
    la = len_of(a1);
    lb = len_of(a2);
    g  = (b2b && m_idle && area_of(a1) != area_of(a2)) ? 1 : 0;
    sb = b2b ? la + g : la + 2;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a1;
    for (int t = 0; t < 14; t++) begin
      @(negedge clk);
      ecs = '1; erdy = 1'b1; ersp = 1'b0;
      if (t < la) begin
        ecs = ~(NAREA'(1) << area_of(a1));
        erdy = (t == la - 1);
      end else if (t >= sb && t < sb + lb) begin
        ecs = ~(NAREA'(1) << area_of(a2));
        erdy = (t == sb + lb - 1);
      end else if (t >= la && t < sb && b2b) begin
        erdy = 1'b0;
      end
      erd = &ecs;
      if (t == la || t == sb + lb) ersp = 1'b1;
      chk({tag, " R2/R11 cs"}, 32'(bus_cs_n), 32'(ecs));
      chk({tag, " R3 rd"}, 32'(bus_rd_n), 32'(erd));
      chk({tag, " R5 ready"}, 32'(req_ready), 32'(erdy));
      chk({tag, " R4 rsp_valid"}, 32'(rsp_valid), 32'(ersp));
      if (t < la) chk({tag, " R2 addr"}, 32'(bus_addr), 32'(a1));
      if (t == la) chk({tag, " R4 data1"}, 32'(rsp_data), 32'(a1 ^ 16'h5A3C));
      if (t == sb + lb) chk({tag, " R4 data2"}, 32'(rsp_data), 32'(a2 ^ 16'h5A3C));
      if (b2b) begin
        if (t == 0) req_addr = a2;
        if (t == la) req_valid = 1'b0;
      end else begin
        if (t == 0) req_valid = 1'b0;
        if (t == la + 1) begin req_valid = 1'b1; req_addr = a2; end
        if (t == la + 2) req_valid = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 act=timeout exp=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    chk("R1 cs reset", 32'(bus_cs_n), 32'hF);
    chk("R1 rd reset", 32'(bus_rd_n), 32'h1);
    chk("R1 rsp reset", 32'(rsp_valid), 32'h0);
    chk("R1 ready reset", 32'(req_ready), 32'h1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 defaults: gap on, three-state everywhere
    run_pair(16'h0123, 16'h4567, 1'b1, "R1/R6 default");
    run_pair(16'h8001, 16'h8002, 1'b1, "R8 same area gap on");
    run_pair(16'hC010, 16'h0020, 1'b0, "R9 idle between");
    do_cfg(1'b0, 4'b0101);
    run_pair(16'h0100, 16'h4200, 1'b1, "R7/R10 gap off 3to2");
    run_pair(16'h4300, 16'h8400, 1'b1, "R7 gap off 2to3");
    do_cfg(1'b1, 4'b0000);
    run_pair(16'hC000, 16'h4FFF, 1'b1, "R6/R3 two-state");
    run_pair(16'hFFFF, 16'hFFFE, 1'b1, "R8 same area top");
    for (int i = 0; i < 150; i++) begin
      if (i % 10 == 0) do_cfg(1'($urandom), 4'($urandom));
      run_pair(16'($urandom), 16'($urandom), 1'($urandom), "rand R6/R7/R8");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule